// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the effective memory address for loads and stores in a small load/store processor. When a memory access updates its base register, it also forms the new base value. Each operation presents a 64-bit base value and an offset. The offset is either a register value shifted left by 0 to 3 places, or a 9-bit signed immediate. A two-bit mode field selects one of four forms: base only, base plus offset, pre-indexed with base update, or post-indexed with base update.

Results are registered. One clock edge after the input valid strobe, the unit presents three things: a memory request with its address and direction, a writeback value with its enable and destination index, and a fault flag. The fault flag marks a negative offset that would carry the address below zero. A faulted operation raises neither the request nor the writeback. A register-to-register move passes through the unit with no memory request and no writeback.

Top module: `agen_unit`

## Requirements
- R1: Outputs are registered. `req_valid`, `wb_en` and `fault` reflect the operation sampled on the clock edge where `in_valid` was high. After an edge with `in_valid` low, all three are low.
- R2: In mode 0 (base only), for a load or store, `req_addr` equals `base_val`, `wb_en` is low and `fault` is low, whatever the offset inputs hold.
- R3: In mode 1 (indexed) with `off_sel`=0, `req_addr` equals `base_val + (off_reg << shamt)` modulo 2^64. Bits shifted past bit 63 are dropped, and `wb_en` stays low.
- R4: With `off_sel`=1, the offset is `off_imm` read as a 9-bit two's-complement value and sign-extended to 64 bits. In this case `shamt` has no effect.
- R5: In mode 2 (pre-indexed), `req_addr` and `wb_val` both equal base plus offset, `wb_en` is high and `wb_idx` equals `base_idx`.
- R6: In mode 3 (post-indexed), `req_addr` equals the unmodified `base_val`, and `wb_val` equals base plus offset with `wb_en` high.
- R7: In modes 1 to 3, a negative offset (bit 63 of the 64-bit offset set) whose sum with `base_val` falls below zero is a fault. Below zero means the unsigned add gives no carry out. A fault raises `fault` and keeps `req_valid` and `wb_en` low. A sum of exactly zero is not a fault.
- R8: `op` 2 (move) and `op` 3 (reserved, handled as a move) produce no request, no writeback and no fault.
- R9: `req_store` is 1 for `op` 1 (store) and 0 for `op` 0 (load).
- R10: While `rst_n` is low, `req_valid`, `wb_en` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| base_val | input | 64 | Base register value |
| base_idx | input | 5 | Base register index |
| off_reg | input | 64 | Offset register value |
| off_imm | input | 9 | Signed immediate offset |
| off_sel | input | 1 | 0 = register offset, 1 = immediate |
| shamt | input | 2 | Left shift applied to the register offset |
| mode | input | 2 | 0 base, 1 indexed, 2 pre-indexed, 3 post-indexed |
| op | input | 2 | 0 load, 1 store, 2 move, 3 reserved |
| req_valid | output | 1 | Memory request valid |
| req_addr | output | 64 | Memory request address |
| req_store | output | 1 | Request is a store |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 64 | Base writeback value |
| wb_idx | output | 5 | Base writeback destination |
| fault | output | 1 | Address underflow fault |

## Verification
Some rules are checked on every cycle. These are the one-cycle output timing, and the base-only address matching the base. The pre-indexed address equals the written-back value, and the post-indexed address equals the old base. Faults and moves never raise a request or writeback. The arithmetic can only be shown by the bench's scenarios. This covers the shifted register offset with bits lost off the top, immediate sign extension at both ends of its range, and the exact boundary where a negative offset lands on zero rather than below it.

// File: rtl/agen_pkg.sv
package agen_pkg;
   typedef enum logic [1:0] {
      AM_BASE  = 2'd0,
      AM_INDEX = 2'd1,
      AM_PRE   = 2'd2,
      AM_POST  = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_MOVE  = 2'd2,
      OP_RSVD  = 2'd3
   } aop_e;

   typedef struct packed {
      logic mem;        // operation touches memory
      logic store;      // direction of the access
      logic wb;         // base register is updated
      logic use_off;    // offset participates in the result
      logic addr_sum;   // address comes from the sum, not the base
   } actl_s;
endpackage

// File: rtl/agen_decode.sv
module agen_decode
   import agen_pkg::*;
(
   input  logic [1:0] mode,
   input  logic [1:0] op,
   output actl_s      ctl
);
   amode_e m;
   aop_e   o;

   always_comb begin
      m = amode_e'(mode);
      o = aop_e'(op);
      ctl.mem      = (o == OP_LOAD) || (o == OP_STORE);
      ctl.store    = (o == OP_STORE);
      ctl.use_off  = (m != AM_BASE);
      ctl.wb       = ctl.mem && ((m == AM_PRE) || (m == AM_POST));
      ctl.addr_sum = (m == AM_INDEX) || (m == AM_PRE);
   end
endmodule

// File: rtl/agen_offset.sv
module agen_offset #(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 9,
   parameter int SH_W   = 2
) (
   input  logic [ADDR_W-1:0] off_reg,
   input  logic [IMM_W-1:0]  off_imm,
   input  logic              off_sel,
   input  logic [SH_W-1:0]   shamt,
   output logic [ADDR_W-1:0] off_val,
   output logic              off_neg
);
   logic [ADDR_W-1:0] reg_scaled;
   logic [ADDR_W-1:0] imm_ext;

   // bits pushed past the top are lost by the fixed result width
   assign reg_scaled = off_reg << shamt;

   generate
      if (IMM_W < ADDR_W) begin : g_sext
         assign imm_ext = {{(ADDR_W-IMM_W){off_imm[IMM_W-1]}}, off_imm};
      end else begin : g_full
         assign imm_ext = off_imm;
      end
   endgenerate

   assign off_val = off_sel ? imm_ext : reg_scaled;
   assign off_neg = off_val[ADDR_W-1];
endmodule

// File: rtl/agen_sum.sv
module agen_sum #(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] off,
   input  logic              off_neg,
   output logic [ADDR_W-1:0] sum,
   output logic              under
);
   logic [ADDR_W:0] wide;

   assign wide  = {1'b0, base} + {1'b0, off};
   assign sum   = wide[ADDR_W-1:0];
   // a negative addend that produces no carry has crossed below zero
   assign under = off_neg & ~wide[ADDR_W];
endmodule

// File: rtl/agen_unit.sv
module agen_unit
   import agen_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 9,
   parameter int SH_W   = 2,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [IDX_W-1:0]  base_idx,
   input  logic [ADDR_W-1:0] off_reg,
   input  logic [IMM_W-1:0]  off_imm,
   input  logic              off_sel,
   input  logic [SH_W-1:0]   shamt,
   input  logic [1:0]        mode,
   input  logic [1:0]        op,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_store,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_val,
   output logic [IDX_W-1:0]  wb_idx,
   output logic              fault
);
   localparam int MAX_SH = (1 << SH_W) - 1;

   generate
      if (IMM_W < 2 || IMM_W >= ADDR_W) begin : g_bad_imm
         $error("agen_unit: IMM_W must lie in 2..ADDR_W-1");
      end
      if (SH_W < 1 || MAX_SH >= ADDR_W) begin : g_bad_sh
         $error("agen_unit: SH_W gives a shift range wider than the address");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("agen_unit: IDX_W must be at least 1");
      end
   endgenerate

   actl_s             ctl;
   logic [ADDR_W-1:0] off_val;
   logic              off_neg;
   logic [ADDR_W-1:0] sum;
   logic              under;
   logic              flt_nx;
   logic              req_nx;
   logic              wb_nx;
   logic [ADDR_W-1:0] addr_nx;

   agen_decode u_dec (
      .mode (mode),
      .op   (op),
      .ctl  (ctl)
   );

   agen_offset #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
      .off_reg (off_reg),
      .off_imm (off_imm),
      .off_sel (off_sel),
      .shamt   (shamt),
      .off_val (off_val),
      .off_neg (off_neg)
   );

   agen_sum #(.ADDR_W(ADDR_W)) u_sum (
      .base    (base_val),
      .off     (off_val),
      .off_neg (off_neg),
      .sum     (sum),
      .under   (under)
   );

   always_comb begin
      flt_nx  = in_valid && ctl.mem && ctl.use_off && under;
      req_nx  = in_valid && ctl.mem && !flt_nx;
      wb_nx   = in_valid && ctl.wb && !flt_nx;
      addr_nx = ctl.addr_sum ? sum : base_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         wb_en     <= 1'b0;
         fault     <= 1'b0;
         req_addr  <= '0;
         req_store <= 1'b0;
         wb_val    <= '0;
         wb_idx    <= '0;
      end else begin
         req_valid <= req_nx;
         wb_en     <= wb_nx;
         fault     <= flt_nx;
         if (in_valid) begin
            req_addr  <= addr_nx;
            req_store <= ctl.store;
            wb_val    <= sum;
            wb_idx    <= base_idx;
         end
      end
   end
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] base_val,
   input logic [IDX_W-1:0]  base_idx,
   input logic [1:0]        mode,
   input logic [1:0]        op,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_val,
   input logic [IDX_W-1:0]  wb_idx,
   input logic              fault
);
   logic mem_op;
   assign mem_op = (op == 2'd0) || (op == 2'd1);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!req_valid && !wb_en && !fault));

   assert_base_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'd0 && mem_op) |=>
         (req_valid && req_addr == $past(base_val) && !wb_en && !fault));

   assert_index_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'd1) |=> !wb_en);

   assert_pre_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'd2 && mem_op) |=>
         (fault || (req_valid && wb_en && req_addr == wb_val && wb_idx == $past(base_idx))));

   assert_post_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'd3 && mem_op) |=>
         (fault || (req_valid && wb_en && req_addr == $past(base_val))));

   assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!req_valid && !wb_en));

   assert_move_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mem_op) |=> (!req_valid && !wb_en && !fault));
endmodule

bind agen_unit agen_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .base_val  (base_val),
   .base_idx  (base_idx),
   .mode      (mode),
   .op        (op),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .wb_en     (wb_en),
   .wb_val    (wb_val),
   .wb_idx    (wb_idx),
   .fault     (fault)
);

// File: tb/agen_unit_test.sv
`timescale 1ns/1ps
module agen_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] base_val = '0;
   logic [4:0]  base_idx = '0;
   logic [63:0] off_reg = '0;
   logic [8:0]  off_imm = '0;
   logic        off_sel = 1'b0;
   logic [1:0]  shamt = '0;
   logic [1:0]  mode = '0;
   logic [1:0]  op = '0;
   logic        req_valid, req_store, wb_en, fault;
   logic [63:0] req_addr, wb_val;
   logic [4:0]  wb_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   agen_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .base_val(base_val), .base_idx(base_idx), .off_reg(off_reg),
      .off_imm(off_imm), .off_sel(off_sel), .shamt(shamt),
      .mode(mode), .op(op), .req_valid(req_valid), .req_addr(req_addr),
      .req_store(req_store), .wb_en(wb_en), .wb_val(wb_val),
      .wb_idx(wb_idx), .fault(fault)
   );

   typedef struct packed {
      logic [1:0]  md;
      logic [1:0]  o;
      logic        sel;
      logic [1:0]  sh;
      logic [63:0] b;
      logic [63:0] orr;
      logic [8:0]  im;
      logic        rv;
      logic [63:0] ad;
      logic        we;
      logic [63:0] wv;
      logic        fl;
      logic [15:0] rq;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      // mode op sel sh base offreg imm | rv addr we wbval fault req
      '{2'd0, 2'd0, 1'b0, 2'd0, 64'h1000, 64'h55, 9'h000, 1'b1, 64'h1000, 1'b0, 64'h0, 1'b0, "R2"},
      '{2'd0, 2'd1, 1'b0, 2'd3, 64'h2000, 64'h0, 9'h000, 1'b1, 64'h2000, 1'b0, 64'h0, 1'b0, "R9"},
      '{2'd1, 2'd0, 1'b0, 2'd2, 64'h1000, 64'h10, 9'h000, 1'b1, 64'h1040, 1'b0, 64'h0, 1'b0, "R3"},
      '{2'd1, 2'd1, 1'b0, 2'd3, 64'h100, 64'h8, 9'h000, 1'b1, 64'h140, 1'b0, 64'h0, 1'b0, "R3"},
      '{2'd1, 2'd0, 1'b0, 2'd0, 64'h100, 64'hFFFF_FFFF_FFFF_FFFC, 9'h000, 1'b1, 64'hFC, 1'b0, 64'h0, 1'b0, "R7"},
      '{2'd1, 2'd0, 1'b0, 2'd0, 64'h10, 64'hFFFF_FFFF_FFFF_FFE0, 9'h000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, "R7"},
      '{2'd2, 2'd0, 1'b1, 2'd3, 64'h1000, 64'hDEAD, 9'h020, 1'b1, 64'h1020, 1'b1, 64'h1020, 1'b0, "R5"},
      '{2'd3, 2'd1, 1'b1, 2'd0, 64'h1000, 64'h0, 9'h1F0, 1'b1, 64'h1000, 1'b1, 64'hFF0, 1'b0, "R6"},
      '{2'd2, 2'd1, 1'b0, 2'd1, 64'h200, 64'h8, 9'h000, 1'b1, 64'h210, 1'b1, 64'h210, 1'b0, "R5"},
      '{2'd2, 2'd2, 1'b0, 2'd0, 64'h300, 64'h4, 9'h000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, "R8"},
      '{2'd3, 2'd0, 1'b1, 2'd0, 64'h8, 64'h0, 9'h1F0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, "R7"},
      '{2'd2, 2'd0, 1'b1, 2'd0, 64'h10, 64'h0, 9'h1F0, 1'b1, 64'h0, 1'b1, 64'h0, 1'b0, "R7"},
      '{2'd1, 2'd0, 1'b0, 2'd2, 64'h0, 64'hC000_0000_0000_0001, 9'h000, 1'b1, 64'h4, 1'b0, 64'h0, 1'b0, "R3"},
      '{2'd1, 2'd0, 1'b1, 2'd0, 64'h0, 64'h0, 9'h0FF, 1'b1, 64'hFF, 1'b0, 64'h0, 1'b0, "R4"},
      '{2'd1, 2'd0, 1'b1, 2'd0, 64'h100, 64'h0, 9'h100, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, "R4"},
      '{2'd0, 2'd3, 1'b0, 2'd0, 64'h500, 64'h0, 9'h000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, "R8"},
      '{2'd3, 2'd0, 1'b0, 2'd2, 64'h40, 64'hFFFF_FFFF_FFFF_FFF0, 9'h000, 1'b1, 64'h40, 1'b1, 64'h0, 1'b0, "R6"},
      '{2'd0, 2'd0, 1'b0, 2'd0, 64'h0, 64'hFFFF_FFFF_FFFF_FF00, 9'h000, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, "R2"}
   };

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] md, input logic [1:0] o, input logic sel,
                        input logic [1:0] sh, input logic [63:0] b, input logic [63:0] orr,
                        input logic [8:0] im, input logic [4:0] idx);
      in_valid = 1'b1; mode = md; op = o; off_sel = sel; shamt = sh;
      base_val = b; off_reg = orr; off_imm = im; base_idx = idx;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: flags low while reset is held
      chk("R10", "req_valid", {63'd0, req_valid}, 64'd0);
      chk("R10", "wb_en", {63'd0, wb_en}, 64'd0);
      chk("R10", "fault", {63'd0, fault}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string rq;
         v = VECS[i];
         rq = string'(v.rq);
         drive(v.md, v.o, v.sel, v.sh, v.b, v.orr, v.im, 5'd7);
         @(negedge clk);
         in_valid = 1'b0;
         chk(rq, $sformatf("v%0d req_valid", i), {63'd0, req_valid}, {63'd0, v.rv});
         chk(rq, $sformatf("v%0d wb_en", i), {63'd0, wb_en}, {63'd0, v.we});
         chk(rq, $sformatf("v%0d fault", i), {63'd0, fault}, {63'd0, v.fl});
         if (v.rv) begin
            chk(rq, $sformatf("v%0d req_addr", i), req_addr, v.ad);
            chk("R9", $sformatf("v%0d req_store", i), {63'd0, req_store}, {63'd0, v.o[0]});
         end
         if (v.we) chk(rq, $sformatf("v%0d wb_val", i), wb_val, v.wv);
      end

      // R1: result appears one edge after the strobe, then clears when idle
      @(negedge clk);
      drive(2'd2, 2'd0, 1'b1, 2'd0, 64'h800, 64'h0, 9'h008, 5'd19);
      chk("R1", "req_valid before edge", {63'd0, req_valid}, 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1", "req_valid after edge", {63'd0, req_valid}, 64'd1);
      chk("R5", "wb_idx", {59'd0, wb_idx}, 64'd19);
      chk("R5", "wb_val", wb_val, 64'h808);
      @(negedge clk);
      chk("R1", "req_valid idle", {63'd0, req_valid}, 64'd0);
      chk("R1", "wb_en idle", {63'd0, wb_en}, 64'd0);

      // R7 then R2 back to back: fault clears on a following good operation
      drive(2'd1, 2'd1, 1'b1, 2'd0, 64'h4, 64'h0, 9'h1FB, 5'd2);
      @(negedge clk);
      chk("R7", "fault b2b", {63'd0, fault}, 64'd1);
      drive(2'd0, 2'd1, 1'b1, 2'd0, 64'h4, 64'h0, 9'h1FB, 5'd2);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", "fault cleared", {63'd0, fault}, 64'd0);
      chk("R2", "addr b2b", req_addr, 64'h4);

      // R10: reset mid-stream clears flags
      drive(2'd2, 2'd0, 1'b0, 2'd0, 64'h40, 64'h4, 9'h0, 5'd1);
      rst_n = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10", "req_valid in reset", {63'd0, req_valid}, 64'd0);
      chk("R10", "wb_en in reset", {63'd0, wb_en}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule